// File: doc/BRIEF.md
# Burst Execution Mode Controller

This block decides how many CPU instruction steps run for each pulse of a slow external clock. A CPU core clocked by a fast internal clock advances one instruction in every fast cycle where the step enable is high. The controller watches the slow clock and, on qualifying edges, raises the step enable for a single cycle or for a whole burst of consecutive cycles.

Software programs the controller through a word-addressed register write port. A mode register selects one of the following:
- single stepping;
- bursts on the rising edge of the slow clock;
- bursts on both edges of the slow clock;
- an optional instruction budget.

A budget register holds the budget value. Register writes go first into staged copies. The staged copies become active only when the slow clock rises.

A burst ends at the earliest of three events:
- the CPU reports fetching one of the two reserved stop opcodes;
- the budget is used up;
- software raises the end-burst input.

The CPU datapath itself lies outside this block.

Top module: `burst_exec_ctrl`

## Requirements
- R1: After reset, `stepEn` is low, and both the active mode and the active budget are zero.
- R2: With fast execution off, each rising edge of `slowClk` gives exactly one step cycle, and a falling edge gives none.
- R3: A write to address 0x00CA loads the staged mode: bit 0 is fast execute, bit 1 is dual edge, bit 2 is budget protection. A write to 0x00CB loads the staged budget. Writes to any other address change nothing.
- R4: With fast execution on, a rising edge of `slowClk` starts a burst. A burst is a run of consecutive cycles with `stepEn` high, one cycle per instruction.
- R5: A falling edge of `slowClk` also starts a burst, but only when both fast execute and dual edge are set.
- R6: A step cycle in which `opValid` is high and `opCode` is 0x0000 or 0x0001 is the last step of its burst.
- R7: With protection on and fast execution on, a burst has at most as many steps as the active budget.
- R8: With protection on, a budget of zero gives no step at all. In single-step mode with protection on and a nonzero budget, a rising edge gives exactly one step.
- R9: Staged mode and budget values become active only on a rising edge of `slowClk`. A falling edge that comes after a write still uses the previously active values.
- R10: A step cycle in which `endBurst` is high is the last step of its burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowClk | input | 1 | Slow external clock, asynchronous to `clk` |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 16 | Register write word address |
| wrData | input | 16 | Register write data |
| opValid | input | 1 | `opCode` holds the opcode of the current step |
| opCode | input | 16 | Opcode fetched in the current step |
| endBurst | input | 1 | Software request to make the current step the last one |
| stepEn | output | 1 | One instruction step runs in each cycle this is high |

## Verification
The in-design checks make three assumptions:
- `opValid` and `endBurst` only matter in cycles where `stepEn` is high;
- `slowClk` holds each level for many fast cycles, so that at most one synchronised edge is in flight at a time;
- a burst that is not capped by the budget ends through a stop opcode or `endBurst`.

The stimulus respects these assumptions in the following ways:
- Each slow-clock phase lasts 40 fast cycles, which is longer than any burst plus the synchroniser delay.
- A CPU model raises `opValid` only alongside `stepEn`.
- Every uncapped burst is given a stop opcode or an end request at a chosen step index.
- All register writes fall inside a slow-clock phase, never next to an edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int MODE_W        = 3;
  localparam int MODE_FAST_BIT = 0;
  localparam int MODE_DUAL_BIT = 1;
  localparam int MODE_PROT_BIT = 2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } burstState_t;

  // control -> datapath
  typedef struct packed {
    logic loadBurst;  // latch limit, clear step counter
    logic incCnt;     // one step executed this cycle
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic riseStart;
    logic fallEdge;
    logic fastOn;
    logic dualOn;
    logic limitZero;
    logic lastStep;
    logic haltSeen;
    logic burstFast;
  } dpStatus_t;

endpackage

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h00CA,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'h00CB,
  parameter logic [DATA_W-1:0] STOP_OP_A = 16'h0000,
  parameter logic [DATA_W-1:0] STOP_OP_B = 16'h0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              opValid,
  input  logic [DATA_W-1:0] opCode,
  input  logic              stepActive,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status
);

  localparam int CNT_W = DATA_W;

  // slow clock synchroniser and edge detect
  logic [SYNC_STAGES-1:0] syncRg;
  logic slowS, slowD, riseEv, fallEv, risePend;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncRg <= '0;
        else       syncRg <= slowClk;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncRg <= '0;
        else       syncRg <= {syncRg[SYNC_STAGES-2:0], slowClk};
      end
    end
  endgenerate

  assign slowS  = syncRg[SYNC_STAGES-1];
  assign riseEv = slowS & ~slowD;
  assign fallEv = ~slowS & slowD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowD    <= 1'b0;
      risePend <= 1'b0;
    end else begin
      slowD    <= slowS;
      risePend <= riseEv;
    end
  end

  // staged and active registers
  logic [MODE_W-1:0] stagedMode, activeMode;
  logic [CNT_W-1:0]  stagedProt, activeProt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedMode <= '0;
      stagedProt <= '0;
    end else if (wrEn) begin
      if (wrAddr == MODE_ADDR) stagedMode <= wrData[MODE_W-1:0];
      if (wrAddr == PROT_ADDR) stagedProt <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeMode <= '0;
      activeProt <= '0;
    end else if (riseEv) begin
      activeMode <= stagedMode;
      activeProt <= stagedProt;
    end
  end

  // burst limit
  logic             fastOn, protOn, limitedNow;
  logic [CNT_W-1:0] limitVal;

  assign fastOn     = activeMode[MODE_FAST_BIT];
  assign protOn     = activeMode[MODE_PROT_BIT];
  assign limitedNow = protOn | ~fastOn;

  always_comb begin
    if (!protOn)     limitVal = CNT_W'(1);
    else if (fastOn) limitVal = activeProt;
    else             limitVal = (activeProt != '0) ? CNT_W'(1) : '0;
  end

  logic [CNT_W-1:0] burstLimit, stepCnt;
  logic             burstLimited, burstFast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstLimit   <= '0;
      burstLimited <= 1'b0;
      burstFast    <= 1'b0;
      stepCnt      <= '0;
    end else if (strobe.loadBurst) begin
      burstLimit   <= limitVal;
      burstLimited <= limitedNow;
      burstFast    <= fastOn;
      stepCnt      <= '0;
    end else if (strobe.incCnt && burstLimited) begin
      stepCnt <= stepCnt + CNT_W'(1);
    end
  end

  logic [CNT_W:0] cntNext;
  assign cntNext = {1'b0, stepCnt} + (CNT_W+1)'(1);

  assign status.riseStart = risePend;
  assign status.fallEdge  = fallEv;
  assign status.fastOn    = fastOn;
  assign status.dualOn    = activeMode[MODE_DUAL_BIT];
  assign status.limitZero = limitedNow && (limitVal == '0);
  assign status.lastStep  = burstLimited && (cntNext == {1'b0, burstLimit});
  assign status.haltSeen  = opValid && (opCode == STOP_OP_A || opCode == STOP_OP_B);
  assign status.burstFast = burstFast;

  // budget is never exceeded while stepping
  p_budget_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stepActive && burstLimited) |-> (stepCnt < burstLimit));

  // active values move only on a synchronised rising edge
  p_commit_on_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    !riseEv |=> ($stable(activeMode) && $stable(activeProt)));

  // a single-step burst is always limited
  p_single_limited_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stepActive && !burstFast) |-> burstLimited);

endmodule

// File: rtl/burst_control.sv
module burst_control
  import burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic        endBurst,
  output ctrlStrobe_t strobe,
  output logic        stepEn
);

  burstState_t state, stateNxt;
  logic startReq, stopNow;

  assign startReq = status.riseStart |
                    (status.fallEdge & status.fastOn & status.dualOn);
  assign stopNow  = status.haltSeen | endBurst | status.lastStep;

  always_comb begin
    stateNxt         = state;
    strobe.loadBurst = 1'b0;
    strobe.incCnt    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.loadBurst = 1'b1;
          if (!status.limitZero) stateNxt = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.incCnt = 1'b1;
        if (stopNow) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign stepEn = (state == ST_RUN);

  p_stop_opcode_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && status.haltSeen) |=> !stepEn);

  p_end_request_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && endBurst) |=> !stepEn);

  p_zero_budget_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && startReq && status.limitZero) |=> !stepEn);

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !status.burstFast) |=> !stepEn);

endmodule

// File: rtl/burst_exec_ctrl.sv
module burst_exec_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              opValid,
  input  logic [DATA_W-1:0] opCode,
  input  logic              endBurst,
  output logic              stepEn
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  burst_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .slowClk    (slowClk),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .opValid    (opValid),
    .opCode     (opCode),
    .stepActive (stepEn),
    .strobe     (strobe),
    .status     (status)
  );

  burst_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .status   (status),
    .endBurst (endBurst),
    .strobe   (strobe),
    .stepEn   (stepEn)
  );

endmodule

// File: tb/sim_burst_exec_ctrl.sv
`timescale 1ns/1ps
module sim_burst_exec_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowClk = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        opValid = 1'b0;
  logic [15:0] opCode = 16'h4321;
  logic        endBurst = 1'b0;
  logic        stepEn;

  always #2.5 clk = ~clk;

  burst_exec_ctrl u0 (
    .clk      (clk),
    .rstN     (rstN),
    .slowClk  (slowClk),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .opValid  (opValid),
    .opCode   (opCode),
    .endBurst (endBurst),
    .stepEn   (stepEn)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // scoreboard
  int    expQ[$];
  string tagQ[$];
  int    closeTok = 0;
  int    seenTok = 0;
  int    winCnt = 0;

  // step index (1-based within a window) at which a stop opcode / end request appears; 0 = never
  int          haltIdx = 0;
  logic [15:0] haltCode = 16'h0000;
  int          endIdx = 0;

  task automatic wrReg(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic edgeWin(input int expSteps, input string tag);
    @(negedge clk);
    slowClk = ~slowClk;
    repeat (40) @(negedge clk);
    @(posedge clk);
    expQ.push_back(expSteps);
    tagQ.push_back(tag);
    closeTok++;
  endtask

  // CPU model and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (stepEn) begin
        winCnt++;
        opValid  = 1'b1;
        opCode   = (winCnt == haltIdx) ? haltCode : 16'h4321;
        endBurst = (winCnt == endIdx);
      end else begin
        opValid  = 1'b0;
        opCode   = 16'h4321;
        endBurst = 1'b0;
      end
      if (closeTok != seenTok) begin
        int e;
        string t;
        seenTok++;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        total++;
        if (winCnt != e) begin
          bad++;
          $display("FAIL %s: steps=%0d expected=%0d", t, winCnt, e);
        end
        winCnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    total++;
    if (stepEn !== 1'b0 || winCnt != 0) begin
      bad++;
      $display("FAIL R1: stepEn=%b steps=%0d expected stepEn=0 steps=0", stepEn, winCnt);
    end

    // R2 single step
    edgeWin(1, "R2 rise single");
    edgeWin(0, "R2 fall single");

    // R4 fast burst, R6 stop opcode 0x0000
    wrReg(16'h00CA, 16'h0001);
    haltIdx = 5; haltCode = 16'h0000;
    edgeWin(5, "R4 R6 rise fast stop0");
    edgeWin(0, "R5 fall without dual");

    // R6 stop opcode 0x0001
    haltIdx = 3; haltCode = 16'h0001;
    edgeWin(3, "R6 rise stop1");
    edgeWin(0, "R5 fall without dual");

    // R5 dual edge
    wrReg(16'h00CA, 16'h0003);
    haltIdx = 4; haltCode = 16'h0000;
    edgeWin(4, "R5 rise dual");
    edgeWin(4, "R5 fall dual");

    // R7 protection budget
    wrReg(16'h00CB, 16'd7);
    wrReg(16'h00CA, 16'h0007);
    haltIdx = 0;
    edgeWin(7, "R7 rise budget");
    edgeWin(7, "R7 fall budget");
    haltIdx = 2;
    edgeWin(2, "R7 R6 stop before budget");
    edgeWin(2, "R7 R6 stop before budget fall");

    // R8 zero budget, R9 staging
    haltIdx = 0;
    wrReg(16'h00CB, 16'd0);
    edgeWin(0, "R8 rise zero budget");
    wrReg(16'h00CB, 16'd9);
    edgeWin(0, "R9 fall keeps old budget");
    edgeWin(9, "R9 rise commits budget");
    edgeWin(9, "R9 fall new budget");

    // R8 single step with protection
    wrReg(16'h00CA, 16'h0004);
    wrReg(16'h00CB, 16'd0);
    edgeWin(0, "R8 single zero budget");
    edgeWin(0, "R8 fall single");
    wrReg(16'h00CB, 16'd5);
    edgeWin(1, "R8 single nonzero budget");
    edgeWin(0, "R8 fall single");

    // R10 end request
    wrReg(16'h00CA, 16'h0001);
    endIdx = 6;
    edgeWin(6, "R10 end request");
    edgeWin(0, "R10 fall");
    endIdx = 0;

    // R3 foreign address ignored
    wrReg(16'h00CC, 16'h0000);
    wrReg(16'h00C9, 16'h0004);
    haltIdx = 3;
    edgeWin(3, "R3 foreign write ignored");
    edgeWin(0, "R3 fall");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule